// File: doc/BRIEF.md
# Serial-Addressed Eight-Channel Trim Register Bank

This block is the digital front end of an eight-channel trim converter. A host drives a three-wire serial port made of a serial clock, a data line and a load strobe. All three are sampled into the system clock domain. Each rising serial clock seen while load is low shifts one bit into a 12-bit word register. The first four bits of a word form a channel address and the last eight bits form the channel value, both sent MSB first. A rising edge of the load strobe decodes the address and writes the value into one of eight channel registers. Some address codes are defined as no-operation.

The last stage of the word register drives a serial output, so that several devices can share one clock and one load line and be chained data-out to data-in. An asynchronous active-low preset forces every channel register to mid-scale (0x80) without waiting for a clock. The preset leaves the word register as it is. The eight channel values leave the block on one flat bus, with channel k in bits [8k+7:8k].

Top module: `trimbank_top`

## Requirements
- R1: A synchronous active-high reset sets all eight channel registers to 0x80 and clears the word register, so the serial output reads 0.
- R2: While preset_n is low, every channel register reads 0x80. This takes effect at once, independent of the system clock, and has priority over any write.
- R3: Each rising ser_clk sampled while ser_load is low shifts ser_din into bit 0 of the 12-bit word. On a rising ser_load, word bits [11:8] are the address and bits [7:0] are the value, so the first bit sent is the address MSB. Address codes 1 to 8 write channels 0 to 7.
- R4: Address code 0 and codes 9 to 15 are no-operation, and a load with one of them changes no channel register.
- R5: While ser_load is high, ser_clk and ser_din are ignored and the word register and ser_dout hold their values.
- R6: ser_dout is the last stage of the word register. It equals the ser_din bit shifted in exactly twelve ser_clk rising edges earlier, and it changes on the same system clock edge that performs the shift.
- R7: A load pulse of any length writes exactly once, on its rising edge. A channel preset while the strobe stays high keeps 0x80 after the preset is released.
- R8: The preset does not disturb the word register. A load after a preset writes the word that was shifted in before the preset.
- R9: A load writes only the addressed channel, and every other channel keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_n | input | 1 | Asynchronous active-low preset of all channels to 0x80 |
| ser_clk | input | 1 | Serial shift clock, rising-edge active |
| ser_din | input | 1 | Serial data input |
| ser_load | input | 1 | Load strobe; its rising edge writes the decoded channel |
| ser_dout | output | 1 | Serial data output for chaining, taken from the last word stage |
| chan_val | output | 64 | Eight channel values, channel k at bits [8k+7:8k] |

## Verification
The bench sweeps every address code and all 256 values against a model of the channel array. A decoder that wraps the no-operation codes onto real channels, or that is off by one in its address, shows up there as a corrupted channel. It checks ser_dout bit by bit over a 24-bit stream, which catches a chain that is eleven or thirteen stages long. It also toggles the serial clock while load is high and then reloads after a preset. A design that keeps shifting during load, or that clears the word on preset, writes the wrong value at that point. Finally, it asserts the preset in the middle of a long load pulse. A level-sensitive write would restore the old value once the preset is released.

// File: rtl/trimbank_pkg.sv
package trimbank_pkg;
  // Value forced into every channel by reset and preset.
  localparam int unsigned MID_CODE = 128;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } slot_t;

  // Address code 1..nch selects channel code-1; all else is no-op.
  function automatic slot_t decode_slot(input int unsigned code, input int unsigned nch);
    slot_t s;
    s.hit = (code >= 1) && (code <= nch);
    s.idx = s.hit ? 8'(code - 1) : 8'd0;
    return s;
  endfunction
endpackage

// File: rtl/serial_front.sv
module serial_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_din,
  input  logic ser_load,
  output logic shift_en,
  output logic din_s,
  output logic load_lvl,
  output logic load_rise
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] clk_pipe, load_pipe;
  logic [SYNC_STAGES-1:0] din_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe  <= '0;
      load_pipe <= '0;
      din_pipe  <= '0;
    end else begin
      clk_pipe  <= {clk_pipe[DEPTH-2:0], ser_clk};
      load_pipe <= {load_pipe[DEPTH-2:0], ser_load};
      din_pipe  <= {din_pipe[SYNC_STAGES-2:0], ser_din};
    end
  end

  assign din_s     = din_pipe[SYNC_STAGES-1];
  assign load_lvl  = load_pipe[SYNC_STAGES-1];
  assign load_rise = load_pipe[SYNC_STAGES-1] & ~load_pipe[SYNC_STAGES];
  assign shift_en  = clk_pipe[SYNC_STAGES-1] & ~clk_pipe[SYNC_STAGES] & ~load_lvl;

  // R7
  load_once_chk: assert property (@(posedge clk) disable iff (rst)
    load_rise |=> !load_rise);
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic              load_lvl,
  output logic [WORD_W-1:0] word,
  output logic              dout
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)           sh <= '0;
    else if (shift_en) sh <= {sh[WORD_W-2:0], din};
  end

  assign word = sh;
  assign dout = sh[WORD_W-1];

  // R5
  load_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    load_lvl |=> $stable(sh));
  // R6
  entry_bit_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sh[0] == $past(din)));
endmodule

// File: rtl/chan_bank.sv
module chan_bank
  import trimbank_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  preset_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     data,
  output logic [NCH*DATA_W-1:0] vals
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(MID_CODE);

  slot_t            sel;
  logic [NCH-1:0]   we;
  logic [NCH*DATA_W-1:0] all_mid;

  always_comb begin
    sel = decode_slot(int'(addr), NCH);
    we  = '0;
    if (wr && sel.hit) we[sel.idx] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)  r <= MID;
        else if (rst)   r <= MID;
        else if (we[g]) r <= data;
      end
      assign vals[g*DATA_W +: DATA_W] = r;
      assign all_mid[g*DATA_W +: DATA_W] = MID;
    end
  endgenerate

  // R2
  mid_on_preset_chk: assert property (@(posedge clk) disable iff (rst)
    !preset_n |-> (vals == all_mid));
  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
  // R4
  nop_hold_chk: assert property (@(posedge clk) disable iff (rst || !preset_n)
    (wr && !sel.hit) |=> ($stable(vals) || !preset_n));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst || !preset_n)
    !wr |=> ($stable(vals) || !preset_n));
endmodule

// File: rtl/trimbank_top.sv
module trimbank_top #(
  parameter int unsigned NCH         = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  preset_n,
  input  logic                  ser_clk,
  input  logic                  ser_din,
  input  logic                  ser_load,
  output logic                  ser_dout,
  output logic [NCH*DATA_W-1:0] chan_val
);
  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  logic shift_en, din_s, load_lvl, load_rise;
  logic [WORD_W-1:0] word;

  serial_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .shift_en(shift_en), .din_s(din_s),
    .load_lvl(load_lvl), .load_rise(load_rise)
  );

  shift_chain #(.WORD_W(WORD_W)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din_s),
    .load_lvl(load_lvl), .word(word), .dout(ser_dout)
  );

  chan_bank #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .preset_n(preset_n), .wr(load_rise),
    .addr(word[WORD_W-1 -: ADDR_W]), .data(word[DATA_W-1:0]),
    .vals(chan_val)
  );
endmodule

// File: tb/sim_trimbank_top.sv
`timescale 1ns/1ps
module sim_trimbank_top;
  logic clk = 0, rst = 1, preset_n = 1, sclk = 0, sdi = 0, ld = 0;
  logic sdo;
  logic [63:0] vals;
  int checks = 0, fails = 0;
  logic [7:0] exp_v [8];
  bit hist [64];
  bit done = 0;

  always #2 clk = ~clk;

  trimbank_top u0 (.clk(clk), .rst(rst), .preset_n(preset_n), .ser_clk(sclk),
    .ser_din(sdi), .ser_load(ld), .ser_dout(sdo), .chan_val(vals));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); sdi = b; sclk = 0; waitn(4);
    sclk = 1; waitn(4);
  endtask

  task automatic shift_word(input logic [3:0] a, input logic [7:0] d);
    logic [11:0] w;
    w = {a, d};
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
    @(negedge clk); sclk = 0; waitn(2);
  endtask

  task automatic pulse_load();
    @(negedge clk); ld = 1; waitn(5); ld = 0; waitn(5);
  endtask

  task automatic pulse_preset();
    @(negedge clk); preset_n = 0; waitn(2); preset_n = 1; waitn(2);
    for (int k = 0; k < 8; k++) exp_v[k] = 8'h80;
  endtask

  function automatic logic [63:0] packed_exp();
    logic [63:0] p;
    for (int k = 0; k < 8; k++) p[k*8 +: 8] = exp_v[k];
    return p;
  endfunction

  task automatic write_model(input logic [3:0] a, input logic [7:0] d);
    if (a >= 1 && a <= 8) exp_v[a-1] = d;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) exp_v[k] = 8'h80;
    waitn(4); rst = 0; waitn(2);
    // R1: reset state
    chk("R1 reset channels", vals, packed_exp());
    chk("R1 reset sdo", {63'd0, sdo}, 64'd0);

    // R3 R4 R9: every address code, value derived from code
    for (int a = 0; a < 16; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) & 8'hFF);
      shift_word(4'(a), d);
      pulse_load();
      write_model(4'(a), d);
      if (a == 0 || a > 8) chk($sformatf("R4 nop code %0d", a), vals, packed_exp());
      else chk($sformatf("R3 R9 code %0d", a), vals, packed_exp());
    end

    // R3: all 256 values rotated over the channels
    for (int v = 0; v < 256; v++) begin
      logic [3:0] a;
      a = 4'((v % 8) + 1);
      shift_word(a, 8'(v));
      pulse_load();
      write_model(a, 8'(v));
      chk($sformatf("R3 value %0d", v), vals, packed_exp());
    end

    // R2: asynchronous preset, sampled away from any clock edge
    @(posedge clk); #0.7 preset_n = 0; #0.5;
    for (int k = 0; k < 8; k++) exp_v[k] = 8'h80;
    chk("R2 async preset", vals, packed_exp());
    waitn(2); preset_n = 1; waitn(2);
    chk("R2 after release", vals, packed_exp());

    // R6: serial output tracks the bit shifted in twelve edges earlier
    for (int i = 0; i < 24; i++) begin
      bit b;
      b = bit'(((i * 5) ^ (i >> 2)) & 1);
      hist[i] = b;
      send_bit(b);
      if (i >= 12) chk($sformatf("R6 sdo step %0d", i), {63'd0, sdo}, {63'd0, hist[i-11]});
    end
    @(negedge clk); sclk = 0; waitn(2);

    // R5 R8: shift a word, load, clock junk while load high, preset, reload
    shift_word(4'd3, 8'h5A);
    @(negedge clk); ld = 1; waitn(5);
    write_model(4'd3, 8'h5A);
    chk("R3 write ch2", vals, packed_exp());
    begin
      logic sdo_hold;
      sdo_hold = sdo;
      for (int i = 0; i < 12; i++) send_bit(bit'(i & 1));
      chk("R5 sdo frozen under load", {63'd0, sdo}, {63'd0, sdo_hold});
    end
    @(negedge clk); sclk = 0; waitn(2); ld = 0; waitn(5);
    pulse_preset();
    chk("R2 preset clears", vals, packed_exp());
    pulse_load();
    write_model(4'd3, 8'h5A);
    chk("R5 R8 reload kept word", vals, packed_exp());

    // R7: preset during a long load pulse; no second write
    shift_word(4'd5, 8'h11);
    @(negedge clk); ld = 1; waitn(5);
    write_model(4'd5, 8'h11);
    chk("R7 first write", vals, packed_exp());
    pulse_preset();
    waitn(10);
    chk("R7 single write per pulse", vals, packed_exp());
    ld = 0; waitn(5);

    // R1: synchronous reset restores mid-scale and clears the word
    shift_word(4'd8, 8'hF0); pulse_load(); write_model(4'd8, 8'hF0);
    chk("R3 write ch7", vals, packed_exp());
    @(negedge clk); rst = 1; waitn(2); rst = 0; waitn(2);
    for (int k = 0; k < 8; k++) exp_v[k] = 8'h80;
    chk("R1 reset again", vals, packed_exp());
    chk("R1 word cleared", {63'd0, sdo}, 64'd0);
    pulse_load();
    chk("R1 R4 cleared word is nop", vals, packed_exp());

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule